// File: doc/BRIEF.md
# Framing Overhead Bit Collector

This block sits beside a T1 receive framer and picks the overhead bit out of selected frames of the multiframe. In the 24-frame extended-superframe mode it takes the data-link bits. In the 72-frame mode it takes the frame-sync bits. In the 4-frame mode it takes the frame-sync bits too. Every frame, the framer gives it a strobe, the frame number and the received overhead bit. The block writes each sampled bit into a fixed position of a six-bit group.

When a group is complete, the block moves it into a host-visible byte register and raises a request line. It also shows which part of the multiframe the group came from. The host then has twelve frames to read the byte and must write an acknowledge to drop the request. A new group that completes while the request is still up overwrites the byte and sets a sticky overrun flag. The next group is built in a shadow register, so the visible byte only changes at the moment a group completes.

Handshake state machine: states `ST_OFF`, `ST_IDLE`, `ST_PEND` and `ST_OVER`. Its transitions are:

- T_ENABLE: `ST_OFF` to `ST_IDLE` when the mode is active.
- T_RAISE: `ST_IDLE` to `ST_PEND` when a group completes.
- T_ACK: `ST_PEND` or `ST_OVER` to `ST_IDLE` on an acknowledge without a completion.
- T_OVERRUN: `ST_PEND` to `ST_OVER`, or `ST_OVER` to itself, on a completion without an acknowledge.
- T_ACK_RAISE: `ST_PEND` or `ST_OVER` to `ST_PEND` on an acknowledge and a completion in the same cycle.
- T_DISABLE: any state to `ST_OFF` when the mode is inactive.

Top module: `ovh_collect`

## Requirements
- R1: Mode `mode=2'b10` is the 24-frame extended-superframe mode, with frames numbered 1 to 24. The bits of frames 1, 3, 5, 7, 9 and 11 land in `rd_data` bits 0 to 5 in that order. The group completes on frame 11 and reports `grp=0`.
- R2: In the same mode, the bits of frames 13, 15, 17, 19, 21 and 23 land in bits 0 to 5. The group completes on frame 23 and reports `grp=1`.
- R3: Mode `mode=2'b11` is the 72-frame mode. For each base n of 24, 36, 48 and 60, the bits of frames n+2, n+4, n+6, n+8, n+10 and n+12 land in bits 0 to 5. Completion comes on frame n+12, with `grp` equal to 0, 1, 2 and 3 respectively.
- R4: Mode `mode=2'b01` is the 4-frame mode, with frames numbered 1 to 4. Bits from frames 2 and 4 fill bits 0 to 5 in arrival order. The sixth sampled bit completes the group, with `grp=0`.
- R5: Strobes on frames outside the sampled set do not alter any group. These are the even frames in R1/R2 mode, and frames below 26 or odd-numbered frames in R3 mode.
- R6: `rd_data` bits 7 and 6 always read 0.
- R7: `rd_data`, `grp` and `req` update in the cycle after the strobe that completes a group. Before that, the visible register keeps its old value.
- R8: `req` stays high until `host_ack` is pulsed. It is low in the cycle after an acknowledge that coincides with no completion.
- R9: A completion while `req` is high overwrites `rd_data` and sets `ovr`. An acknowledge clears `ovr`. An acknowledge in the same cycle as a completion leaves `req=1` and `ovr=0`.
- R10: With `mode=2'b00`, `req` and `ovr` are low from the next cycle on, and no group is loaded.
- R11: Any change of `mode` discards the partly collected group. A strobe in the cycle of the change is dropped.
- R12: Synchronous `rst` clears `rd_data`, `grp`, `req`, `ovr` and the shadow group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 off, 01 4-frame, 10 extended superframe, 11 72-frame |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| frm_num | input | 7 | Frame number within the multiframe, starting at 1 |
| ovh_bit | input | 1 | Overhead bit value of the strobed frame |
| host_ack | input | 1 | Host acknowledge pulse |
| rd_data | output | 8 | Host-visible group, bits 5..0 used |
| req | output | 1 | Read request to the host |
| grp | output | 2 | Part of the multiframe the group belongs to |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The collector is driven with full multiframes in each mode, using a different bit pattern per run. Ignored frames carry ones, so a wrong slot decode or a wrong bit position shows up as a byte mismatch rather than passing silently. Groups are left unacknowledged on purpose to separate overwrite-with-overrun from the acknowledge-and-complete collision. An all-ones group confirms the upper two bits stay clear. Three further cases tell a true discard apart from stale shadow bits leaking into the next group: a mode change in mid-group, a switch to the off mode with a request pending, and a reset with a request pending.

// File: rtl/ovh_pkg.sv
`timescale 1ns/1ps
package ovh_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_F4  = 2'b01,
        MODE_ESF = 2'b10,
        MODE_F72 = 2'b11
    } ovh_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_PEND,
        ST_OVER
    } hs_state_e;

    // group geometry
    localparam int GRP_BITS   = 6;
    localparam int GRP_SPAN   = 12;
    // extended superframe: odd frames from 1
    localparam int ESF_BASE   = 1;
    localparam int ESF_GROUPS = 2;
    // 72-frame: even frames from 26
    localparam int F72_BASE   = 26;
    localparam int F72_GROUPS = 4;
    // 4-frame: two sampled frames per multiframe
    localparam int F4_SLOT_A  = 2;
    localparam int F4_SLOT_B  = 4;

endpackage

// File: rtl/ovh_slot_map.sv
`timescale 1ns/1ps
module ovh_slot_map
    import ovh_pkg::*;
#(
    parameter int FN_W  = 7,
    parameter int IDX_W = 3,
    parameter int GW    = 2
) (
    input  ovh_mode_e          mode,
    input  logic [FN_W-1:0]    frm_num,
    input  logic [IDX_W-1:0]   f4_pos,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [GW-1:0]      grp,
    output logic               last
);

    localparam logic [FN_W-1:0]  ESF_BASE_W = FN_W'(ESF_BASE);
    localparam logic [FN_W-1:0]  ESF_LIM_W  = FN_W'(ESF_GROUPS * GRP_SPAN);
    localparam logic [FN_W-1:0]  F72_BASE_W = FN_W'(F72_BASE);
    localparam logic [FN_W-1:0]  F72_LIM_W  = FN_W'(F72_GROUPS * GRP_SPAN);
    localparam logic [FN_W-1:0]  SPAN_W     = FN_W'(GRP_SPAN);
    localparam logic [FN_W-1:0]  F4_A_W     = FN_W'(F4_SLOT_A);
    localparam logic [FN_W-1:0]  F4_B_W     = FN_W'(F4_SLOT_B);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(GRP_BITS - 1);

    logic [FN_W-1:0] base;
    logic [FN_W-1:0] lim;
    logic [FN_W-1:0] off;
    logic            spaced;

    // decode frame number into a slot of the current group
    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        grp    = '0;
        base   = '0;
        lim    = '0;
        off    = '0;
        spaced = 1'b0;
        unique case (mode)
            MODE_ESF: begin
                base   = ESF_BASE_W;
                lim    = ESF_LIM_W;
                spaced = 1'b1;
            end
            MODE_F72: begin
                base   = F72_BASE_W;
                lim    = F72_LIM_W;
                spaced = 1'b1;
            end
            MODE_F4: begin
                hit = (frm_num == F4_A_W) || (frm_num == F4_B_W);
                idx = f4_pos;
            end
            MODE_OFF: begin
                hit = 1'b0;
            end
        endcase
        if (spaced && (frm_num >= base)) begin
            off = frm_num - base;
            if ((off < lim) && !off[0]) begin
                hit = 1'b1;
                grp = GW'(off / SPAN_W);
                idx = IDX_W'((off % SPAN_W) >> 1);
            end
        end
    end

    assign last = hit && (idx == LAST_IDX);

endmodule

// File: rtl/ovh_shadow.sv
`timescale 1ns/1ps
module ovh_shadow #(
    parameter int NB    = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             is_f4,
    input  logic [IDX_W-1:0] idx,
    input  logic             ob_in,
    input  logic             last,
    output logic [IDX_W-1:0] f4_pos,
    output logic             done,
    output logic [NB-1:0]    word
);

    logic [NB-1:0]    sh_q;
    logic [IDX_W-1:0] pos_q;

    assign done = take && last;

    // one storage cell per group bit; completed word bypasses the incoming bit
    for (genvar i = 0; i < NB; i++) begin : g_cell
        logic cell_q;
        logic sel;
        assign sel = take && (idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst || clr || done) begin
                cell_q <= 1'b0;
            end else if (sel) begin
                cell_q <= ob_in;
            end
        end
        assign sh_q[i] = cell_q;
        assign word[i] = sel ? ob_in : cell_q;
    end

    // arrival counter used only in the 4-frame mode
    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            pos_q <= '0;
        end else if (take && is_f4) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign f4_pos = pos_q;

    // R11: a mode change leaves an empty shadow group
    a_r11_shadow_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sh_q == '0) && (pos_q == '0));

endmodule

// File: rtl/ovh_hs_fsm.sv
`timescale 1ns/1ps
module ovh_hs_fsm
    import ovh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_ok,
    input  logic done,
    input  logic ack,
    output logic req,
    output logic ovr
);

    hs_state_e state_q;
    hs_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_ok) state_d = ST_IDLE;                  // T_ENABLE
            end
            ST_IDLE: begin
                if (done) state_d = ST_PEND;                     // T_RAISE
            end
            ST_PEND, ST_OVER: begin
                if (ack && done)  state_d = ST_PEND;             // T_ACK_RAISE
                else if (ack)     state_d = ST_IDLE;             // T_ACK
                else if (done)    state_d = ST_OVER;             // T_OVERRUN
            end
        endcase
        if (!mode_ok) state_d = ST_OFF;                          // T_DISABLE
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        req = 1'b0;
        ovr = 1'b0;
        unique case (state_q)
            ST_OFF, ST_IDLE: begin
                req = 1'b0;
                ovr = 1'b0;
            end
            ST_PEND: begin
                req = 1'b1;
            end
            ST_OVER: begin
                req = 1'b1;
                ovr = 1'b1;
            end
        endcase
    end

    // R7: a completion raises the request
    a_r7_raise: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && done) |=> req);
    // R8: acknowledge drops the request
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (ack && !done) |=> !req);
    // R9: unacknowledged completion during a request marks overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && done && req && !ack) |=> ovr);
    // R9: acknowledge colliding with completion
    a_r9_ack_collide: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && done && ack) |=> (req && !ovr));
    // R10: inactive mode keeps the request quiet
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> (!req && !ovr));

endmodule

// File: rtl/ovh_collect.sv
`timescale 1ns/1ps
module ovh_collect
    import ovh_pkg::*;
#(
    parameter int FN_W = 7,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic            frm_stb,
    input  logic [FN_W-1:0] frm_num,
    input  logic            ovh_bit,
    input  logic            host_ack,
    output logic [DW-1:0]   rd_data,
    output logic            req,
    output logic [1:0]      grp,
    output logic            ovr
);

    localparam int IDX_W = $clog2(GRP_BITS);
    localparam int GW    = 2;
    localparam int PAD_W = DW - GRP_BITS;

    ovh_mode_e            mode_e;
    ovh_mode_e            mode_q;
    logic                 chg;
    logic                 mode_ok;
    logic                 hit;
    logic                 last;
    logic                 take;
    logic                 done;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     f4_pos;
    logic [GW-1:0]        slot_grp;
    logic [GRP_BITS-1:0]  word;
    logic [GRP_BITS-1:0]  vis_q;
    logic [GW-1:0]        grp_q;

    assign mode_e  = ovh_mode_e'(mode);
    assign mode_ok = (mode_e != MODE_OFF);
    assign chg     = (mode_e != mode_q);
    assign take    = frm_stb && hit && !chg;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode_e;
    end

    ovh_slot_map #(
        .FN_W  (FN_W),
        .IDX_W (IDX_W),
        .GW    (GW)
    ) u_map (
        .mode    (mode_e),
        .frm_num (frm_num),
        .f4_pos  (f4_pos),
        .hit     (hit),
        .idx     (idx),
        .grp     (slot_grp),
        .last    (last)
    );

    ovh_shadow #(
        .NB    (GRP_BITS),
        .IDX_W (IDX_W)
    ) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .clr    (chg),
        .take   (take),
        .is_f4  (mode_e == MODE_F4),
        .idx    (idx),
        .ob_in  (ovh_bit),
        .last   (last),
        .f4_pos (f4_pos),
        .done   (done),
        .word   (word)
    );

    ovh_hs_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .mode_ok (mode_ok),
        .done    (done),
        .ack     (host_ack),
        .req     (req),
        .ovr     (ovr)
    );

    // host-visible copy loads only on completion
    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q <= '0;
            grp_q <= '0;
        end else if (done) begin
            vis_q <= word;
            grp_q <= slot_grp;
        end
    end

    assign rd_data = {{PAD_W{1'b0}}, vis_q};
    assign grp     = grp_q;

    // R7: visible register holds between completions
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(rd_data) && $stable(grp)));
    // R7: a completion always comes with a raised request
    a_r7_req_on_load: assert property (@(posedge clk) disable iff (rst)
        done |=> req);

endmodule

// File: tb/ovh_collect_tb.sv
`timescale 1ns/1ps
module ovh_collect_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       frm_stb;
    logic [6:0] frm_num;
    logic       ovh_bit;
    logic       host_ack;
    logic [7:0] rd_data;
    logic       req;
    logic [1:0] grp;
    logic       ovr;

    always #2.5 clk = ~clk;

    ovh_collect u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .frm_stb  (frm_stb),
        .frm_num  (frm_num),
        .ovh_bit  (ovh_bit),
        .host_ack (host_ack),
        .rd_data  (rd_data),
        .req      (req),
        .grp      (grp),
        .ovr      (ovr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] g;
        logic       o;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [5:0] m_sh;
    int         m_pos;
    logic       m_req;
    logic       m_ovr;
    logic [7:0] m_data;
    logic [1:0] m_mode;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pat(input int f, input int seed);
        return ((f * 5 + seed * 3) % 7) < 3;
    endfunction

    // expected slot, written from the frame lists of R1..R4
    task automatic model_slot(input int f, output bit hit, output int idx, output int g);
        hit = 0; idx = 0; g = 0;
        case (m_mode)
            2'b10: for (int gg = 0; gg < 2; gg++)
                       for (int k = 0; k < 6; k++)
                           if (f == 12 * gg + 2 * k + 1) begin hit = 1; idx = k; g = gg; end
            2'b11: for (int gg = 0; gg < 4; gg++)
                       for (int k = 0; k < 6; k++)
                           if (f == 24 + 12 * gg + 2 * k + 2) begin hit = 1; idx = k; g = gg; end
            2'b01: if (f == 2 || f == 4) begin hit = 1; idx = m_pos; end
            default: hit = 0;
        endcase
    endtask

    // driver: one strobe, model update, push expected group
    task automatic step_frame(input int f, input bit b, input bit ack, input string tag);
        bit hit; int idx; int g;
        frm_num = 7'(f); ovh_bit = b; frm_stb = 1'b1; host_ack = ack;
        @(posedge clk); #1;
        frm_stb = 1'b0; host_ack = 1'b0;
        model_slot(f, hit, idx, g);
        if (ack) begin m_req = 0; m_ovr = 0; end
        if (hit) begin
            m_sh[idx] = b;
            if (m_mode == 2'b01) m_pos++;
            if (idx == 5) begin
                if (m_req) m_ovr = 1;
                m_req  = 1;
                m_data = {2'b00, m_sh};
                exp_q.push_back('{d: m_data, g: 2'(g), o: m_ovr});
                tag_q.push_back(tag);
                m_sh = '0; m_pos = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_ack(input string tag);
        host_ack = 1'b1;
        @(posedge clk); #1;
        host_ack = 1'b0;
        m_req = 0; m_ovr = 0;
        @(negedge clk);
        chk({tag, " req after ack"}, req, 0);
        chk({tag, " ovr after ack"}, ovr, 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        @(posedge clk); #1;
        if (m != m_mode) begin m_sh = '0; m_pos = 0; end
        m_mode = m;
        if (m == 2'b00) begin m_req = 0; m_ovr = 0; end
        @(negedge clk);
    endtask

    task automatic run(input int lo, input int hi, input int seed, input bit auto_ack, input string tag);
        for (int f = lo; f <= hi; f++) begin
            step_frame(f, (f % 2 == 0 && m_mode == 2'b10) ? 1'b1 : pat(f, seed), 0, tag);
            if (auto_ack && m_req) do_ack(tag);
        end
    endtask

    // monitor: pop expected groups as the design presents them
    exp_t  mon_e;
    string mon_t;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk({mon_t, " data"}, rd_data, mon_e.d);
            chk({mon_t, " grp"}, grp, mon_e.g);
            chk({mon_t, " req"}, req, 1);
            chk({mon_t, " ovr"}, ovr, mon_e.o);
            chk("R6 upper bits", rd_data[7:6], 0);
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 2'b00; frm_stb = 1'b0; frm_num = '0; ovh_bit = 1'b0; host_ack = 1'b0;
        m_sh = '0; m_pos = 0; m_req = 0; m_ovr = 0; m_data = '0; m_mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R12 reset data", rd_data, 0);
        chk("R12 reset req", req, 0);
        chk("R12 reset ovr", ovr, 0);
        chk("R12 reset grp", grp, 0);

        // R1, R5, R7, R8
        set_mode(2'b10);
        run(1, 10, 1, 0, "R1");
        chk("R7 no req before completion", req, 0);
        chk("R7 data held before completion", rd_data, 0);
        run(11, 12, 1, 0, "R1");
        chk("R8 req held", req, 1);
        do_ack("R8");
        // R2 then R9 overwrite with overrun
        run(13, 24, 1, 0, "R2");
        run(1, 24, 2, 0, "R9");
        do_ack("R9");
        // R9 acknowledge colliding with completion
        run(1, 11, 3, 0, "R9");
        run(12, 22, 3, 0, "R9");
        step_frame(23, pat(23, 3), 1, "R9 collide");
        chk("R9 collide req", req, 1);
        chk("R9 collide ovr", ovr, 0);
        do_ack("R9");
        // R6 all-ones group
        for (int f = 13; f <= 23; f++) step_frame(f, 1'b1, 0, "R6");
        chk("R6 all ones", rd_data, 8'h3F);
        do_ack("R6");

        // R3, R5 in 72-frame mode
        set_mode(2'b11);
        run(1, 72, 4, 1, "R3");
        run(1, 72, 5, 1, "R3");

        // R4 in 4-frame mode
        set_mode(2'b01);
        for (int i = 0; i < 24; i++) begin
            step_frame((i % 4) + 1, pat(i, 6), 0, "R4");
            if (m_req) do_ack("R4");
        end

        // R11 mode change discards partial group
        set_mode(2'b10);
        for (int f = 1; f <= 5; f++) step_frame(f, 1'b1, 0, "R11");
        set_mode(2'b11);
        set_mode(2'b10);
        for (int f = 7; f <= 11; f++) step_frame(f, 1'b0, 0, "R11");
        chk("R11 discarded bits", rd_data, 0);
        do_ack("R11");

        // R10 off mode
        run(1, 11, 7, 0, "R10");
        set_mode(2'b00);
        chk("R10 req off", req, 0);
        chk("R10 ovr off", ovr, 0);
        for (int f = 1; f <= 24; f++) step_frame(f, 1'b1, 0, "R10");
        chk("R10 no request", req, 0);
        chk("R10 data kept", rd_data, m_data);

        // R12 reset with request pending
        set_mode(2'b10);
        run(1, 11, 8, 0, "R12");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_req = 0; m_ovr = 0; m_sh = '0; m_data = '0;
        chk("R12 data cleared", rd_data, 0);
        chk("R12 req cleared", req, 0);
        chk("R12 ovr cleared", ovr, 0);
        chk("R12 grp cleared", grp, 0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule